// File: doc/BRIEF.md
# Flash Endurance Sweep Sequencer

This block runs a wear test against a flash command-buffer controller. A command gives an operation (read ID, write or read), a data-pattern algorithm (continuous, checkerboard or random), a first and a last page address and a repeat count. The block then issues the operation to the controller once for every page from the first address up to and including the last. It repeats that sweep the requested number of times. The controller is driven through a start/done handshake: write bytes are pulled with a request strobe, and read bytes come back with a valid strobe.

Write data comes from the selected pattern. Read data is checked against the same pattern, rebuilt on the fly, so the test needs no stored copy of what was written. Pages are grouped into blocks of 2^PAGE_LOG2 pages. When the last page of a block in the range completes, the block emits a status record carrying the pass number, the block number and a pass/fail bit, over a valid/ready handshake. Commands that cannot run are refused with an error flag, and no controller operation is issued for them.

Top module: `wt_sequencer`

## Requirements
- R1: After reset, `busy`, `cmd_err`, `ctl_start`, `ctl_wreq`-driven data consumption and `rec_valid` are all inactive (`busy`=0, `cmd_err`=0, `ctl_start`=0, `rec_valid`=0).
- R2: A `cmd_go` taken while idle is refused when first > last, when the repeat count is 0, when the op code is 3, or when the algorithm code is 3. In that case `cmd_err` is 1 from the next cycle, `busy` stays 0 and `ctl_start` never rises. The next accepted command clears `cmd_err`.
- R3: An accepted command raises `busy` on the next cycle. Each pass presents `ctl_addr` = first, first+1, … last, in order. Each address is announced by a one-cycle `ctl_start` pulse, and the next pulse comes only after `ctl_done`. The sweep runs exactly the repeat count of passes, and `busy` falls on the cycle after the final record is accepted.
- R4: `ctl_op` carries the command's op code unchanged: 0 = read ID, 1 = write, 2 = read.
- R5: Algorithm 0 (continuous): every write byte is 8'h00, and reads expect 8'h00.
- R6: Algorithm 1 (checkerboard): a page's byte is 8'h00 when address bit 0 equals bit 0 of the pass index (passes are counted from 0), and 8'hFF otherwise.
- R7: Algorithm 2 (random): a 32-bit state is loaded with SEED at command accept and at the start of every pass. The byte is state[7:0]. Each byte transferred (a `ctl_wreq` cycle in write, a `ctl_rvalid` cycle in read) steps the state to (s>>1) ^ (s[0] ? 32'h80200003 : 0).
- R8: The block number is address >> PAGE_LOG2. A record is posted after the page whose low PAGE_LOG2 address bits are all ones, or after the last address of the range. `rec_cycle` is the pass index counted from 0.
- R9: `rec_pass` is 0 when, in that pass and block, a read-op byte differed from the expected pattern or a `ctl_done` came with `ctl_fail`=1. Otherwise it is 1. Read-ID data is not compared.
- R10: `rec_valid` stays high with stable `rec_cycle`, `rec_block` and `rec_pass` until `rec_ready`, and no `ctl_start` is issued while a record is pending.
- R11: `cmd_go` while `busy` has no effect on the running sweep's addresses, op or pass count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | Operation code |
| cmd_alg | input | 2 | Pattern algorithm |
| cmd_first | input | ADDR_W | First page address |
| cmd_last | input | ADDR_W | Last page address (inclusive) |
| cmd_reps | input | CNT_W | Number of passes |
| busy | output | 1 | Sweep in progress |
| cmd_err | output | 1 | Last command refused |
| ctl_start | output | 1 | Controller operation start pulse |
| ctl_op | output | 2 | Operation code to controller |
| ctl_addr | output | ADDR_W | Page address to controller |
| ctl_done | input | 1 | Controller operation finished |
| ctl_fail | input | 1 | Controller program/erase status failed |
| ctl_wreq | input | 1 | Controller takes one write byte |
| ctl_wdata | output | DATA_W | Write byte from pattern |
| ctl_rvalid | input | 1 | Read byte valid |
| ctl_rdata | input | DATA_W | Read byte |
| rec_valid | output | 1 | Status record valid |
| rec_ready | input | 1 | Status record accepted |
| rec_cycle | output | CNT_W | Pass index of the record |
| rec_block | output | ADDR_W-PAGE_LOG2 | Block number of the record |
| rec_pass | output | 1 | 1 = block good, 0 = block bad |

## Verification
The bench builds the block with PAGE_LOG2 = 2 and keeps the 24-bit address and count widths and the default SEED. Four-page blocks let ranges of under twenty pages cross several block boundaries. That makes both record triggers reachable: a block's last page, and a range that ends in mid-block. Short ranges with two or three passes show the checkerboard phase flip and the per-pass reseed of the random stream within a few hundred cycles per command.

// File: rtl/wt_pkg.sv
package wt_pkg;

   localparam logic [1:0] OP_RDID  = 2'd0;
   localparam logic [1:0] OP_WRITE = 2'd1;
   localparam logic [1:0] OP_READ  = 2'd2;

   localparam logic [1:0] ALG_CONT  = 2'd0;
   localparam logic [1:0] ALG_CHECK = 2'd1;
   localparam logic [1:0] ALG_RAND  = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_POST
   } wt_state_e;

   function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] mask);
      return (s >> 1) ^ (s[0] ? mask : 32'h0);
   endfunction

endpackage

// File: rtl/wt_cmd_check.sv
module wt_cmd_check #(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 24
) (
   input  logic [1:0]        op,
   input  logic [1:0]        alg,
   input  logic [ADDR_W-1:0] first,
   input  logic [ADDR_W-1:0] last,
   input  logic [CNT_W-1:0]  reps,
   output logic              ok
);
   import wt_pkg::*;

   logic range_ok, reps_ok, codes_ok;

   always_comb begin
      range_ok = (first <= last);
      reps_ok  = (reps != '0);
      codes_ok = (op != 2'd3) && (alg != 2'd3);
      ok       = range_ok && reps_ok && codes_ok;
   end

endmodule

// File: rtl/wt_pattern.sv
module wt_pattern #(
   parameter int          DATA_W = 8,
   parameter logic [31:0] SEED   = 32'hACE1_2B3D,
   parameter logic [31:0] MASK   = 32'h8020_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reseed,
   input  logic              advance,
   input  logic [1:0]        alg,
   input  logic              page_lsb,
   input  logic              pass_lsb,
   output logic [DATA_W-1:0] pat
);
   import wt_pkg::*;

   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("wt_pattern: DATA_W must be 1..32");
   end
   if (SEED == 32'h0) begin : g_bad_seed
      $error("wt_pattern: SEED must be non-zero");
   end

   logic [31:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        state_q <= SEED;
      else if (reseed)   state_q <= SEED;
      else if (advance)  state_q <= lfsr_step(state_q, MASK);
   end

   always_comb begin
      unique case (alg)
         ALG_CHECK: pat = (page_lsb == pass_lsb) ? '0 : '1;
         ALG_RAND:  pat = state_q[DATA_W-1:0];
         default:   pat = '0;
      endcase
   end

endmodule

// File: rtl/wt_block_track.sv
module wt_block_track #(
   parameter int ADDR_W    = 24,
   parameter int PAGE_LOG2 = 6,
   localparam int BLK_W    = ADDR_W - PAGE_LOG2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] last,
   output logic              blk_end,
   output logic [BLK_W-1:0]  blk_id
);
   if (PAGE_LOG2 < 0 || PAGE_LOG2 >= ADDR_W) begin : g_bad_geom
      $error("wt_block_track: PAGE_LOG2 must be 0..ADDR_W-1");
   end

   assign blk_id = addr[ADDR_W-1:PAGE_LOG2];

   if (PAGE_LOG2 == 0) begin : g_page_is_block
      assign blk_end = 1'b1;
   end else begin : g_multi_page
      assign blk_end = (&addr[PAGE_LOG2-1:0]) || (addr == last);
   end

endmodule

// File: rtl/wt_sequencer.sv
module wt_sequencer #(
   parameter int          ADDR_W    = 24,
   parameter int          CNT_W     = 24,
   parameter int          DATA_W    = 8,
   parameter int          PAGE_LOG2 = 6,
   parameter logic [31:0] SEED      = 32'hACE1_2B3D,
   localparam int         BLK_W     = ADDR_W - PAGE_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic [1:0]        cmd_op,
   input  logic [1:0]        cmd_alg,
   input  logic [ADDR_W-1:0] cmd_first,
   input  logic [ADDR_W-1:0] cmd_last,
   input  logic [CNT_W-1:0]  cmd_reps,
   output logic              busy,
   output logic              cmd_err,
   output logic              ctl_start,
   output logic [1:0]        ctl_op,
   output logic [ADDR_W-1:0] ctl_addr,
   input  logic              ctl_done,
   input  logic              ctl_fail,
   input  logic              ctl_wreq,
   output logic [DATA_W-1:0] ctl_wdata,
   input  logic              ctl_rvalid,
   input  logic [DATA_W-1:0] ctl_rdata,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic [CNT_W-1:0]  rec_cycle,
   output logic [BLK_W-1:0]  rec_block,
   output logic              rec_pass
);
   import wt_pkg::*;

   if (CNT_W < 1 || ADDR_W < 2) begin : g_bad_params
      $error("wt_sequencer: CNT_W >= 1 and ADDR_W >= 2 required");
   end

   wt_state_e         state_q;
   logic [1:0]        op_q, alg_q;
   logic [ADDR_W-1:0] first_q, last_q, addr_q;
   logic [CNT_W-1:0]  reps_q, pass_q;
   logic              bad_q, err_q;

   logic              cmd_ok, accept, blk_end, at_last, final_pass;
   logic              reseed, advance, mismatch, wrap;
   logic [DATA_W-1:0] pat;
   logic [BLK_W-1:0]  blk_id;

   wt_cmd_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_check (
      .op(cmd_op), .alg(cmd_alg), .first(cmd_first), .last(cmd_last),
      .reps(cmd_reps), .ok(cmd_ok)
   );

   wt_block_track #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) i_blk (
      .addr(addr_q), .last(last_q), .blk_end(blk_end), .blk_id(blk_id)
   );

   wt_pattern #(.DATA_W(DATA_W), .SEED(SEED)) i_pat (
      .clk(clk), .rst_n(rst_n), .reseed(reseed), .advance(advance),
      .alg(alg_q), .page_lsb(addr_q[0]), .pass_lsb(pass_q[0]), .pat(pat)
   );

   always_comb begin
      accept     = (state_q == ST_IDLE) && cmd_go && cmd_ok;
      at_last    = (addr_q == last_q);
      final_pass = (pass_q == reps_q - CNT_W'(1));
      wrap       = (state_q == ST_POST) && rec_ready && at_last && !final_pass;
      reseed     = accept || wrap;
      advance    = (state_q == ST_WAIT) &&
                   ((ctl_wreq && op_q == OP_WRITE) || (ctl_rvalid && op_q == OP_READ));
      mismatch   = (state_q == ST_WAIT) && ctl_rvalid && (op_q == OP_READ) && (ctl_rdata != pat);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= '0;
         alg_q   <= '0;
         first_q <= '0;
         last_q  <= '0;
         reps_q  <= '0;
         addr_q  <= '0;
         pass_q  <= '0;
         bad_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cmd_go) begin
               err_q <= !cmd_ok;
               if (cmd_ok) begin
                  op_q    <= cmd_op;
                  alg_q   <= cmd_alg;
                  first_q <= cmd_first;
                  last_q  <= cmd_last;
                  reps_q  <= cmd_reps;
                  addr_q  <= cmd_first;
                  pass_q  <= '0;
                  bad_q   <= 1'b0;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (mismatch || (ctl_done && ctl_fail)) bad_q <= 1'b1;
               if (ctl_done) begin
                  if (blk_end) state_q <= ST_POST;
                  else begin
                     addr_q  <= addr_q + ADDR_W'(1);
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_POST: if (rec_ready) begin
               bad_q <= 1'b0;
               if (!at_last) begin
                  addr_q  <= addr_q + ADDR_W'(1);
                  state_q <= ST_ISSUE;
               end else if (final_pass) begin
                  state_q <= ST_IDLE;
               end else begin
                  addr_q  <= first_q;
                  pass_q  <= pass_q + CNT_W'(1);
                  state_q <= ST_ISSUE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign cmd_err   = err_q;
   assign ctl_start = (state_q == ST_ISSUE);
   assign ctl_op    = op_q;
   assign ctl_addr  = addr_q;
   assign ctl_wdata = pat;
   assign rec_valid = (state_q == ST_POST);
   assign rec_cycle = pass_q;
   assign rec_block = blk_id;
   assign rec_pass  = !bad_q;

   // R3: one-cycle start pulse, address kept inside the programmed range
   p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_start |=> !ctl_start);
   p_addr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_start |-> (ctl_addr >= first_q && ctl_addr <= last_q));
   // R2: refused command leaves the block idle with the error flag up
   p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && !busy && !cmd_ok) |=> (!busy && cmd_err && !ctl_start));
   // R10: record held stable until taken, controller quiet meanwhile
   p_rec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_block) &&
                                     $stable(rec_cycle) && $stable(rec_pass)));
   p_rec_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !ctl_start);
   // R11: a command strobe during a sweep does not touch its settings
   p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_go) |=> ($stable(first_q) && $stable(last_q) &&
                            $stable(reps_q) && $stable(ctl_op)));

endmodule

// File: tb/test_wt_sequencer.sv
module test_wt_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int CW = 24;
   localparam int PL = 2;
   localparam int NBYTES = 4;
   localparam logic [31:0] SEED = 32'hACE1_2B3D;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_go = 0;
   logic [1:0] cmd_op = 0, cmd_alg = 0;
   logic [AW-1:0] cmd_first = 0, cmd_last = 0;
   logic [CW-1:0] cmd_reps = 0;
   logic busy, cmd_err, ctl_start;
   logic [1:0] ctl_op;
   logic [AW-1:0] ctl_addr;
   logic ctl_done = 0, ctl_fail = 0, ctl_wreq = 0, ctl_rvalid = 0;
   logic [7:0] ctl_wdata;
   logic [7:0] ctl_rdata = 0;
   logic rec_valid, rec_ready = 0, rec_pass;
   logic [CW-1:0] rec_cycle;
   logic [AW-PL-1:0] rec_block;

   int checks = 0, fails = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wt_sequencer #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(8), .PAGE_LOG2(PL), .SEED(SEED)) i_wt_sequencer (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_alg(cmd_alg),
      .cmd_first(cmd_first), .cmd_last(cmd_last), .cmd_reps(cmd_reps),
      .busy(busy), .cmd_err(cmd_err), .ctl_start(ctl_start), .ctl_op(ctl_op),
      .ctl_addr(ctl_addr), .ctl_done(ctl_done), .ctl_fail(ctl_fail),
      .ctl_wreq(ctl_wreq), .ctl_wdata(ctl_wdata), .ctl_rvalid(ctl_rvalid),
      .ctl_rdata(ctl_rdata), .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_cycle(rec_cycle), .rec_block(rec_block), .rec_pass(rec_pass)
   );

   task automatic summary();
      $display("test done: total=%0d bad=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; fails++;
         $display("FAIL R3 watchdog expired actual=%0d expected<=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] step(input logic [31:0] s);
      return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
   endfunction

   function automatic logic [7:0] exp_byte(input logic [1:0] alg, input logic [AW-1:0] a,
                                           input int p, input logic [31:0] s);
      if (alg == 2'd1) return (a[0] == p[0]) ? 8'h00 : 8'hFF;
      if (alg == 2'd2) return s[7:0];
      return 8'h00;
   endfunction

   task automatic reject(input logic [1:0] op, input logic [1:0] alg,
                         input logic [AW-1:0] f, input logic [AW-1:0] l, input logic [CW-1:0] r);
      @(negedge clk);
      cmd_op = op; cmd_alg = alg; cmd_first = f; cmd_last = l; cmd_reps = r; cmd_go = 1;
      @(negedge clk);
      cmd_go = 0;
      chk(cmd_err === 1'b1, "R2 cmd_err", 32'(cmd_err), 1);
      repeat (3) begin
         chk(busy === 1'b0 && ctl_start === 1'b0, "R2 no op issued", {busy, ctl_start}, 0);
         @(negedge clk);
      end
   endtask

   // corrupt/fail addresses of -1 mean none
   task automatic run_cmd(input logic [1:0] op, input logic [1:0] alg,
                          input logic [AW-1:0] f, input logic [AW-1:0] l, input int reps,
                          input int bad_addr, input int bad_pass,
                          input int fail_addr, input int fail_pass, input bit poke);
      logic [31:0] s;
      bit blk_bad;
      string rq;
      @(negedge clk);
      cmd_op = op; cmd_alg = alg; cmd_first = f; cmd_last = l; cmd_reps = CW'(reps); cmd_go = 1;
      @(negedge clk);
      cmd_go = 0;
      chk(busy === 1'b1, "R3 busy after accept", 32'(busy), 1);
      chk(cmd_err === 1'b0, "R2 err cleared", 32'(cmd_err), 0);
      rq = (alg == 2'd0) ? "R5" : (alg == 2'd1) ? "R6" : "R7";
      for (int p = 0; p < reps; p++) begin
         s = SEED;
         blk_bad = 0;
         for (int a = int'(f); a <= int'(l); a++) begin
            while (!ctl_start) @(negedge clk);
            chk(ctl_addr === AW'(a), "R3 address order", 32'(ctl_addr), 32'(a));
            chk(ctl_op === op, "R4 op forwarded", 32'(ctl_op), 32'(op));
            @(negedge clk);
            chk(ctl_start === 1'b0, "R3 start is one cycle", 32'(ctl_start), 0);
            if (poke && p == 0 && a == int'(f)) begin
               cmd_op = 2'd0; cmd_first = l + 5; cmd_last = l + 9; cmd_reps = 7; cmd_go = 1;
               @(negedge clk);
               cmd_go = 0;
            end
            if (op == 2'd1) begin
               for (int b = 0; b < NBYTES; b++) begin
                  ctl_wreq = 1; #1;
                  chk(ctl_wdata === exp_byte(alg, AW'(a), p, s), {rq, " write byte"},
                      32'(ctl_wdata), 32'(exp_byte(alg, AW'(a), p, s)));
                  s = step(s);
                  @(negedge clk);
               end
               ctl_wreq = 0;
            end else if (op == 2'd2) begin
               for (int b = 0; b < NBYTES; b++) begin
                  ctl_rvalid = 1;
                  ctl_rdata = exp_byte(alg, AW'(a), p, s);
                  if (a == bad_addr && p == bad_pass && b == 1) begin
                     ctl_rdata = ctl_rdata ^ 8'h10;
                     blk_bad = 1;
                  end
                  s = step(s);
                  @(negedge clk);
               end
               ctl_rvalid = 0;
            end else begin
               // read ID: bytes returned are not compared
               ctl_rvalid = 1; ctl_rdata = 8'h5A;
               @(negedge clk);
               ctl_rvalid = 0;
            end
            ctl_done = 1;
            ctl_fail = (a == fail_addr && p == fail_pass);
            if (ctl_fail) blk_bad = 1;
            @(negedge clk);
            ctl_done = 0; ctl_fail = 0;
            if (a[PL-1:0] == '1 || a == int'(l)) begin
               chk(rec_valid === 1'b1, "R8 record posted", 32'(rec_valid), 1);
               chk(rec_block === (AW-PL)'(a >> PL), "R8 block number", 32'(rec_block), 32'(a >> PL));
               chk(rec_cycle === CW'(p), "R8 pass index", 32'(rec_cycle), 32'(p));
               chk(rec_pass === !blk_bad, "R9 pass bit", 32'(rec_pass), 32'(!blk_bad));
               repeat ($urandom % 3) begin
                  @(negedge clk);
                  chk(rec_valid === 1'b1 && ctl_start === 1'b0 && rec_pass === !blk_bad &&
                      rec_block === (AW-PL)'(a >> PL), "R10 record held",
                      {rec_valid, ctl_start, rec_pass}, {1'b1, 1'b0, !blk_bad});
               end
               rec_ready = 1;
               @(negedge clk);
               rec_ready = 0;
               blk_bad = 0;
            end else begin
               chk(rec_valid === 1'b0, "R8 no record mid-block", 32'(rec_valid), 0);
            end
         end
      end
      chk(busy === 1'b0, poke ? "R11 sweep unaffected by busy cmd_go" : "R3 busy falls at end",
          32'(busy), 0);
   endtask

   initial begin
      int unsigned sd;
      sd = $urandom(1234);
      repeat (3) @(negedge clk);
      chk(busy === 0 && cmd_err === 0 && ctl_start === 0 && rec_valid === 0,
          "R1 reset state", {busy, cmd_err, ctl_start, rec_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(busy === 0 && rec_valid === 0, "R1 idle after reset", {busy, rec_valid}, 0);

      // R2 refusals
      reject(2'd1, 2'd0, 24'd9, 24'd3, 24'd1);
      reject(2'd1, 2'd0, 24'd2, 24'd3, 24'd0);
      reject(2'd3, 2'd0, 24'd2, 24'd3, 24'd1);
      reject(2'd1, 2'd3, 24'd2, 24'd3, 24'd1);

      // R5 continuous write across block boundary, 2 passes
      run_cmd(2'd1, 2'd0, 24'd2, 24'd9, 2, -1, 0, -1, 0, 0);
      // R6 checkerboard write, 3 passes, phase flip
      run_cmd(2'd1, 2'd1, 24'd3, 24'd6, 3, -1, 0, -1, 0, 0);
      // R7 random write and read with corruption in pass 1
      run_cmd(2'd1, 2'd2, 24'd0, 24'd5, 2, -1, 0, -1, 0, 0);
      run_cmd(2'd2, 2'd2, 24'd0, 24'd5, 2, 5, 1, -1, 0, 0);
      // R9 checkerboard read with controller status fail
      run_cmd(2'd2, 2'd1, 24'd4, 24'd8, 2, -1, 0, 6, 0, 0);
      // R4 read ID, single address range
      run_cmd(2'd0, 2'd0, 24'd7, 24'd7, 1, -1, 0, 7, 0, 0);
      run_cmd(2'd0, 2'd0, 24'd12, 24'd12, 2, -1, 0, -1, 0, 0);
      // R11 cmd_go while busy
      run_cmd(2'd1, 2'd0, 24'd1, 24'd4, 2, -1, 0, -1, 0, 1);

      // constrained random commands
      for (int k = 0; k < 8; k++) begin
         logic [1:0] op, alg;
         int f, len, r, ba, fa;
         op  = 2'd1 + 2'($urandom % 2);
         alg = 2'($urandom % 3);
         f   = $urandom % 20;
         len = $urandom % 9;
         r   = 1 + $urandom % 3;
         ba  = ($urandom % 2 != 0) ? f + int'($urandom % (len + 1)) : -1;
         fa  = ($urandom % 3 == 0) ? f + int'($urandom % (len + 1)) : -1;
         run_cmd(op, alg, AW'(f), AW'(f + len), r, ba, int'($urandom % r), fa,
                 int'($urandom % r), 0);
      end

      summary();
      $finish;
   end
endmodule